// File: doc/BRIEF.md
# Rename Register Pool with In-Order Commit

This block keeps the speculative results of in-flight instructions in a small pool of rename entries. It copies each result into a 32-entry architectural register file only when the instruction that produced it retires. Dispatch asks for an entry for each instruction that writes a register. It gets back a tag naming that entry, or a stall when every entry is in use. Execution units and returning loads write their results into the entry named by the tag. The entry stays not-ready until that write arrives.

Retirement names tags in program order. The oldest entry, once it holds its result, is copied into its architectural register and freed, at most one per cycle. A flush drops every entry that has not retired and leaves the architectural file untouched. Two operand-read ports look up any architectural register number. Each returns the value from the youngest rename entry aimed at that register if one exists, and the committed value otherwise, together with a ready flag.

Top module: `rename_commit_rf`

## Requirements
- R1: After reset the pool is empty, `alloc_stall` is 0, and every read port returns value 0 with `rd_ready` 1 for every register number.
- R2: When `alloc_req` is high, `flush` is low and fewer than 4 entries are held, `alloc_grant` is high in the same cycle. `alloc_tag` names the entry. Tags are handed out in the sequence 0, 1, 2, 3, 0, ... From the next cycle the entry is held and not ready.
- R3: While 4 entries are held, `alloc_stall` is 1 and `alloc_grant` is 0, even in a cycle in which the oldest entry retires.
- R4: A write-back (`wb_en`) to a held entry stores `wb_data` and marks the entry ready from the next cycle. A write-back to a tag that is not held has no effect.
- R5: When `retire_en` is high, `retire_tag` equals the oldest held entry's tag, and that entry is ready, the entry's value is written to its architectural register and the entry is freed at the next edge. One entry retires per cycle at most.
- R6: A retire request that names a tag other than the oldest, or whose oldest entry is not ready, changes nothing.
- R7: A read of register r returns the youngest held entry aimed at r. `rd_ready` follows that entry's ready flag, and the value is that entry's data when ready.
- R8: A read of register r with no held entry aimed at r returns the committed architectural value with `rd_ready` 1.
- R9: `flush` frees every held entry at the next edge and leaves the architectural file unchanged. Allocation and retirement requests in the flush cycle are ignored, and the next allocation gets tag 0.
- R10: The two read ports look up independent register numbers in the same cycle.
- R11: Allocation may be granted in every consecutive cycle while entries remain free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Dispatch asks for a rename entry |
| alloc_dst | input | 5 | Architectural destination of the new entry |
| alloc_grant | output | 1 | Entry granted this cycle |
| alloc_tag | output | 2 | Tag of the granted entry |
| alloc_stall | output | 1 | All entries are held |
| wb_en | input | 1 | Result write-back strobe |
| wb_tag | input | 2 | Entry receiving the result |
| wb_data | input | 32 | Result value |
| retire_en | input | 1 | Retire request |
| retire_tag | input | 2 | Tag being retired, in program order |
| flush | input | 1 | Drop all unretired entries |
| rd_idx | input | 2x5 | Register number per read port |
| rd_data | output | 2x32 | Read value per port |
| rd_ready | output | 2 | Read value is available per port |

## Verification
The bench aims at register aliasing. Several held entries name the same register, and a design that picked the oldest instead of the youngest would return stale data or a wrong ready flag. It also drives retirement at a full pool, where a design that counted the freed entry would grant into a slot still being committed. Wrong-tag and not-ready retire requests, and write-backs to freed tags, must leave every read unchanged. A flush must also leave committed values intact, and a design that let it commit or restart tags elsewhere shows up on the next read sweep or tag.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    localparam int ARCH_REGS = 32;
    localparam int AIDX_W    = $clog2(ARCH_REGS);
    localparam int XLEN      = 32;
    localparam int POOL      = 4;
    localparam int TAG_W     = $clog2(POOL);
    localparam int CNT_W     = $clog2(POOL + 1);
    localparam int RD_PORTS  = 2;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [AIDX_W-1:0] aidx_t;
    typedef logic [XLEN-1:0]   word_t;

    typedef struct packed {
        logic  held;
        logic  done;
        aidx_t dst;
        word_t val;
    } slot_t;

    typedef struct packed {
        logic  hit;
        logic  done;
        word_t val;
    } probe_t;

    function automatic tag_t tag_after(tag_t t, int unsigned k);
        return t + tag_t'(k);
    endfunction
endpackage

// File: rtl/rrf_ring_ctrl.sv
module rrf_ring_ctrl
    import rrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             alloc_req,
    input  logic             retire_fire,
    output logic             grant,
    output logic             full,
    output tag_t             head,
    output tag_t             tail,
    output logic [CNT_W-1:0] count
);
    assign full  = (count == CNT_W'(POOL));
    assign grant = alloc_req && !flush && !full;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (grant)       tail <= tag_after(tail, 1);
            if (retire_fire) head <= tag_after(head, 1);
            count <= count + CNT_W'(grant) - CNT_W'(retire_fire);
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(POOL));
    p_full_no_growth_r3: assert property (@(posedge clk) disable iff (rst)
        (full && !flush) |=> (count <= $past(count)));
    p_flush_restart_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && head == '0 && tail == '0));
    p_head_step_r5: assert property (@(posedge clk) disable iff (rst)
        (retire_fire && !flush) |=> (head == tag_after($past(head), 1)));
endmodule

// File: rtl/rrf_arch_file.sv
module rrf_arch_file
    import rrf_pkg::*;
#(
    parameter int NREGS = ARCH_REGS,
    parameter int NRD   = RD_PORTS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  aidx_t                 widx,
    input  word_t                 wdata,
    input  aidx_t [NRD-1:0]       ridx,
    output word_t [NRD-1:0]       rdata
);
    word_t [NREGS-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst)     regs       <= '0;
        else if (we) regs[widx] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = regs[ridx[p]];
    end

    p_hold_without_commit_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs));
    p_commit_lands_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/rrf_lookup.sv
module rrf_lookup
    import rrf_pkg::*;
(
    input  slot_t  slots [POOL],
    input  tag_t   head,
    input  aidx_t  ridx,
    output probe_t res
);
    always_comb begin
        res = '0;
        // walk oldest to youngest so the last match wins
        for (int k = 0; k < POOL; k++) begin
            tag_t s;
            s = tag_after(head, k);
            if (slots[s].held && slots[s].dst == ridx) begin
                res.hit  = 1'b1;
                res.done = slots[s].done;
                res.val  = slots[s].val;
            end
        end
    end
endmodule

// File: rtl/rename_commit_rf.sv
module rename_commit_rf
    import rrf_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           alloc_req,
    input  logic [AIDX_W-1:0]              alloc_dst,
    output logic                           alloc_grant,
    output logic [TAG_W-1:0]               alloc_tag,
    output logic                           alloc_stall,
    input  logic                           wb_en,
    input  logic [TAG_W-1:0]               wb_tag,
    input  logic [XLEN-1:0]                wb_data,
    input  logic                           retire_en,
    input  logic [TAG_W-1:0]               retire_tag,
    input  logic                           flush,
    input  logic [RD_PORTS-1:0][AIDX_W-1:0] rd_idx,
    output logic [RD_PORTS-1:0][XLEN-1:0]  rd_data,
    output logic [RD_PORTS-1:0]            rd_ready
);
    slot_t            slots [POOL];
    tag_t             head, tail;
    logic [CNT_W-1:0] count;
    logic             full, grant, retire_fire;
    word_t [RD_PORTS-1:0] arch_val;

    assign retire_fire = retire_en && !flush && (retire_tag == head)
                       && slots[head].held && slots[head].done;

    rrf_ring_ctrl u_ring (
        .clk(clk), .rst(rst), .flush(flush), .alloc_req(alloc_req),
        .retire_fire(retire_fire), .grant(grant), .full(full),
        .head(head), .tail(tail), .count(count)
    );

    assign alloc_grant = grant;
    assign alloc_tag   = tail;
    assign alloc_stall = full;

    for (genvar i = 0; i < POOL; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slots[i] <= '0;
            end else if (grant && tail == tag_t'(i)) begin
                slots[i].held <= 1'b1;
                slots[i].done <= 1'b0;
                slots[i].dst  <= alloc_dst;
                slots[i].val  <= '0;
            end else if (retire_fire && head == tag_t'(i)) begin
                slots[i].held <= 1'b0;
                slots[i].done <= 1'b0;
            end else if (wb_en && wb_tag == tag_t'(i) && slots[i].held) begin
                slots[i].done <= 1'b1;
                slots[i].val  <= wb_data;
            end
        end
    end

    rrf_arch_file #(.NREGS(ARCH_REGS), .NRD(RD_PORTS)) u_arch (
        .clk(clk), .rst(rst), .we(retire_fire),
        .widx(slots[head].dst), .wdata(slots[head].val),
        .ridx(rd_idx), .rdata(arch_val)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        probe_t pr;
        rrf_lookup u_look (
            .slots(slots), .head(head), .ridx(rd_idx[p]), .res(pr)
        );
        assign rd_data[p]  = pr.hit ? pr.val  : arch_val[p];
        assign rd_ready[p] = pr.hit ? pr.done : 1'b1;
    end

    p_alloc_opens_r2: assert property (@(posedge clk) disable iff (rst)
        alloc_grant |=> (slots[$past(alloc_tag)].held && !slots[$past(alloc_tag)].done));
    p_wb_marks_done_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !flush && slots[wb_tag].held && !(retire_fire && head == wb_tag))
        |=> (slots[$past(wb_tag)].done && slots[$past(wb_tag)].val == $past(wb_data)));
    p_retire_frees_r5: assert property (@(posedge clk) disable iff (rst)
        retire_fire |=> !slots[$past(head)].held);
endmodule

// File: tb/rename_commit_rf_test.sv
module rename_commit_rf_test;
    logic clk = 1'b0;
    logic rst;
    logic alloc_req; logic [4:0] alloc_dst;
    logic alloc_grant; logic [1:0] alloc_tag; logic alloc_stall;
    logic wb_en; logic [1:0] wb_tag; logic [31:0] wb_data;
    logic retire_en; logic [1:0] retire_tag; logic flush;
    logic [1:0][4:0] rd_idx; logic [1:0][31:0] rd_data; logic [1:0] rd_ready;

    int checks = 0, failures = 0;
    bit finished = 0;

    // bench model
    bit        m_held [4]; bit m_done [4];
    logic [4:0]  m_dst [4]; logic [31:0] m_val [4];
    logic [31:0] m_arch [32];
    int m_head, m_tail, m_count;
    logic [31:0] lfsr = 32'hACE1_2357;

    rename_commit_rf uut (.*);

    always #2 clk = ~clk;

    task automatic chk(string lbl, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    task automatic m_read(int r, output logic [31:0] v, output logic rdy);
        v = m_arch[r]; rdy = 1'b1;
        for (int k = 0; k < 4; k++) begin
            int s = (m_head + k) % 4;
            if (m_held[s] && m_dst[s] == r[4:0]) begin
                v = m_done[s] ? m_val[s] : 32'h0; rdy = m_done[s];
            end
        end
    endtask

    task automatic sweep(string lbl);
        for (int r = 0; r < 32; r++) begin
            logic [31:0] v0, v1; logic k0, k1;
            rd_idx[0] = 5'(r); rd_idx[1] = 5'(31 - ((r * 7) % 32));
            #1;
            m_read(r, v0, k0); m_read(int'(rd_idx[1]), v1, k1);
            chk(lbl, {31'b0, rd_ready[0]}, {31'b0, k0});
            if (k0) chk(lbl, rd_data[0], v0);
            chk(lbl, {31'b0, rd_ready[1]}, {31'b0, k1});
            if (k1) chk(lbl, rd_data[1], v1);
        end
    endtask

    task automatic step(bit areq, logic [4:0] adst, bit wen, logic [1:0] wtag,
                        logic [31:0] wdat, bit ren, logic [1:0] rtag, bit fl,
                        string lbl);
        bit g, rfire, wok;
        @(negedge clk);
        alloc_req = areq; alloc_dst = adst; wb_en = wen; wb_tag = wtag;
        wb_data = wdat; retire_en = ren; retire_tag = rtag; flush = fl;
        #1;
        g = areq && !fl && (m_count != 4);
        chk({lbl, " R2 R3 grant"}, {31'b0, alloc_grant}, {31'b0, g});
        chk({lbl, " R3 stall"}, {31'b0, alloc_stall}, {31'b0, m_count == 4});
        if (g) chk({lbl, " R2 tag"}, {30'b0, alloc_tag}, 32'(m_tail));
        @(posedge clk);
        rfire = ren && !fl && m_held[m_head] && m_done[m_head] && (int'(rtag) == m_head);
        wok = wen && m_held[wtag] && !(rfire && int'(wtag) == m_head);
        if (fl) begin
            for (int s = 0; s < 4; s++) begin m_held[s] = 0; m_done[s] = 0; end
            m_head = 0; m_tail = 0; m_count = 0;
        end else begin
            if (rfire) begin
                m_arch[m_dst[m_head]] = m_val[m_head];
                m_held[m_head] = 0; m_done[m_head] = 0;
            end
            if (wok) begin m_done[wtag] = 1; m_val[wtag] = wdat; end
            if (g) begin
                m_held[m_tail] = 1; m_done[m_tail] = 0;
                m_dst[m_tail] = adst; m_val[m_tail] = 0;
                m_tail = (m_tail + 1) % 4;
            end
            if (rfire) m_head = (m_head + 1) % 4;
            m_count = m_count + int'(g) - int'(rfire);
        end
        #1;
        alloc_req = 0; wb_en = 0; retire_en = 0; flush = 0;
        sweep({lbl, " R7 R8 R10"});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; alloc_req = 0; alloc_dst = 0; wb_en = 0; wb_tag = 0; wb_data = 0;
        retire_en = 0; retire_tag = 0; flush = 0; rd_idx = '0;
        for (int s = 0; s < 4; s++) begin m_held[s] = 0; m_done[s] = 0; m_dst[s] = 0; m_val[s] = 0; end
        for (int r = 0; r < 32; r++) m_arch[r] = 0;
        m_head = 0; m_tail = 0; m_count = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1 stall after reset", {31'b0, alloc_stall}, 32'd0);
        sweep("R1");

        // back-to-back fill, aliasing on register 5
        step(1, 5'd5, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 5'd5, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 5'd7, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 5'd9, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 5'd3, 0, 0, 0, 0, 0, 0, "R3 full");
        step(0, 0, 1, 2'd0, 32'hAAAA_0001, 0, 0, 0, "R4 R7 older ready");
        step(0, 0, 1, 2'd1, 32'hBBBB_0002, 0, 0, 0, "R4 R7 younger ready");
        step(0, 0, 0, 0, 0, 1, 2'd1, 0, "R6 wrong tag");
        step(1, 5'd3, 0, 0, 0, 1, 2'd0, 0, "R3 R5 retire at full");
        step(0, 0, 0, 0, 0, 1, 2'd1, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 2'd2, 0, "R6 not ready");
        step(0, 0, 1, 2'd0, 32'hDEAD_BEEF, 0, 0, 0, "R4 freed tag");
        step(0, 0, 1, 2'd2, 32'hCCCC_0003, 0, 0, 0, "R4");
        step(1, 5'd4, 0, 0, 0, 1, 2'd2, 1, "R9 flush");
        step(1, 5'd4, 0, 0, 0, 0, 0, 0, "R9 restart");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");

        // sweep every architectural register through commit
        for (int r = 0; r < 32; r++) begin
            logic [1:0] t = 2'(m_tail);
            step(1, 5'(r), 0, 0, 0, 0, 0, 0, "R2 R8");
            step(0, 0, 1, t, 32'h1000_0001 * (r + 3), 0, 0, 0, "R4");
            step(0, 0, 0, 0, 0, 1, t, 0, "R5 R8");
        end

        // pseudo-random mixed traffic
        for (int n = 0; n < 500; n++) begin
            logic [4:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = lfsr[7] ? lfsr[12:8] : {2'b0, lfsr[10:8]};
            step(lfsr[0] | lfsr[1], d, lfsr[13], lfsr[15:14], lfsr ^ 32'h5A5A_0000,
                 lfsr[16] | lfsr[17], lfsr[18] ? 2'(m_head) : lfsr[20:19],
                 lfsr[24:21] == 4'd0, "R10 mixed");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule